// File: doc/BRIEF.md
# Interrupt Acceptance Flag Sequencer

This block carries out the state update a small processor core makes once it has accepted an interrupt. An accept strobe arrives with the following inputs:

- the class of the interrupt;
- a software vector number;
- the granted priority level;
- the live flag register, program counter and the two stack pointers.

The block picks a stack and pushes three 16-bit words through a plain memory write port. It then moves the chosen stack pointer down and presents the new flag register together with a one-cycle done pulse.

The stack choice depends on the class. Software vectors 32 and above keep the stack the core was already using. Every other class is forced onto the interrupt stack and has its stack-select flag cleared. The interrupt level field is handled by class:

- reset clears it;
- non-maskable and watchdog entries raise it to the top level;
- maskable entries load the granted level;
- debug and software entries keep it.

A separate detector watches the non-maskable pin. It synchronises the pin and latches a falling edge as a pending request, which stays set until the core accepts a non-maskable entry.

Top module: `irq_accept_seq`

## Requirements
- R1: An accept strobe sampled while idle starts a sequence. `memWe` is high for exactly the three cycles that follow that clock edge, and `busy` is high from then until the done cycle ends.
- R2: The three pushes go to descending addresses below the chosen stack pointer SP: the flag word at SP-2, then the program counter bits 19:16 zero-extended at SP-4, then PC bits 15:0 at SP-6. That pointer's output ends at SP-6.
- R3: The class codes are 0 reset, 1 non-maskable, 2 watchdog, 3 debug break, 4 single step, 5 address match, 6 software and 7 maskable. For class 6 with a vector of 32 or more, the stack is the one chosen by flag bit 7 (U, 1 = user stack) at acceptance, and U keeps its value. All other entries use the interrupt stack and clear U in the new flags.
- R4: The new flags have bit 6 (interrupt enable) and bit 1 (debug) cleared. All other bits come from the flag value at acceptance, apart from U and the level field. The pushed flag word is the value at acceptance, unchanged.
- R5: The level field, flag bits 14:12, becomes 0 for reset, 7 for non-maskable and watchdog, and the granted level for maskable. It stays unchanged for classes 3, 4, 5 and 6.
- R6: The stack pointer that is not used holds the value it was given at acceptance for the whole sequence.
- R7: `done` is a one-cycle pulse in the fourth cycle after the accept edge. `flagOut` takes its new value in that same cycle and changes at no other time.
- R8: An accept strobe while `busy` is high has no effect on the pushes, the stack pointers, the flags or the sequence length.
- R9: A high-to-low change on `nmiPin` sets `nmiPending` on the third clock edge after the change. A rising edge or a steady level does not set it. Once set, it stays set until an accept of class 1 is sampled while idle, which clears it on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acceptStrobe | input | 1 | Interrupt accepted this cycle |
| irqClass | input | 3 | Class code of the accepted interrupt |
| swVector | input | 6 | Software vector number |
| acceptLevel | input | 3 | Priority level of the accepted request |
| flagIn | input | 16 | Current flag register |
| pcIn | input | 20 | Current program counter |
| ispIn | input | 16 | Current interrupt stack pointer |
| uspIn | input | 16 | Current user stack pointer |
| nmiPin | input | 1 | Non-maskable interrupt pin, active low edge |
| memWe | output | 1 | Stack write enable |
| memAddr | output | 16 | Stack write address |
| memData | output | 16 | Stack write data |
| ispOut | output | 16 | Updated interrupt stack pointer |
| uspOut | output | 16 | Updated user stack pointer |
| flagOut | output | 16 | Updated flag register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete pulse |
| nmiPending | output | 1 | Latched non-maskable request |

## Verification
Counting from the edge that samples the accept strobe, the three writes are due in the first, second and third cycles after it. The final stack pointer, the new flags and `done` are all due in the fourth cycle, and the block is idle in the fifth. The bench drives on falling edges and steps exactly one rising edge per observation, so each result is read in the cycle the requirements set for it. The pending flag for the pin is checked just before and just after the third edge that follows the pin change.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  localparam int FLAG_W  = 16;
  localparam int PC_W    = 20;
  localparam int SP_W    = 16;
  localparam int LVL_W   = 3;
  localparam int VEC_W   = 6;
  localparam int BIT_DBG = 1;
  localparam int BIT_IE  = 6;
  localparam int BIT_USR = 7;
  localparam int IPL_LSB = 12;
  localparam int SW_KEEP_BASE = 32;
  localparam int WORD_BYTES   = 2;

  typedef enum logic [2:0] {
    CLS_RESET    = 3'd0,
    CLS_NMI      = 3'd1,
    CLS_WDOG     = 3'd2,
    CLS_DBGBRK   = 3'd3,
    CLS_STEP     = 3'd4,
    CLS_ADDRHIT  = 3'd5,
    CLS_SOFT     = 3'd6,
    CLS_MASKABLE = 3'd7
  } irqClass_e;

  typedef enum logic [1:0] {
    WORD_FLAG = 2'd0,
    WORD_PCHI = 2'd1,
    WORD_PCLO = 2'd2
  } pushWord_e;

  typedef struct packed {
    logic      load;
    logic      push;
    pushWord_e word;
    logic      commit;
  } seqStrobe_t;
endpackage

// File: rtl/irqseq_nmi_edge.sv
module irqseq_nmi_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic nmiPin,
  input  logic ack,
  output logic pending
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;
  logic fall;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[CHAIN_W-2:0], nmiPin};
  end

  assign fall = chain[CHAIN_W-1] & ~chain[CHAIN_W-2];

  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= fall | (pending & ~ack);
  end

  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !ack) |=> pending); // R9
  AST_NMI_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !fall) |=> !pending); // R9
endmodule

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
  import irqseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       acceptStrobe,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_PFLG, ST_PHI, ST_PLO, ST_DONE
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (acceptStrobe) stateNext = ST_PFLG;
      ST_PFLG: stateNext = ST_PHI;
      ST_PHI:  stateNext = ST_PLO;
      ST_PLO:  stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.load   = (state == ST_IDLE) && acceptStrobe;
    strobe.push   = (state == ST_PFLG) || (state == ST_PHI) || (state == ST_PLO);
    strobe.commit = (state == ST_PLO);
    case (state)
      ST_PHI:  strobe.word = WORD_PCHI;
      ST_PLO:  strobe.word = WORD_PCLO;
      default: strobe.word = WORD_FLAG;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  AST_START_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (strobe.push && strobe.word == WORD_FLAG)); // R1
  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.word == WORD_PCLO) |=> done); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.load); // R8
endmodule

// File: rtl/irqseq_datapath.sv
module irqseq_datapath
  import irqseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [2:0]        irqClass,
  input  logic [VEC_W-1:0]  swVector,
  input  logic [LVL_W-1:0]  acceptLevel,
  input  logic [FLAG_W-1:0] flagIn,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [SP_W-1:0]   ispIn,
  input  logic [SP_W-1:0]   uspIn,
  output logic              memWe,
  output logic [SP_W-1:0]   memAddr,
  output logic [SP_W-1:0]   memData,
  output logic [SP_W-1:0]   ispOut,
  output logic [SP_W-1:0]   uspOut,
  output logic [FLAG_W-1:0] flagOut
);
  localparam logic [SP_W-1:0] STEP = SP_W'(WORD_BYTES);

  irqClass_e         inClass, heldClass;
  logic [SP_W-1:0]   ispReg, uspReg, activeSp;
  logic [FLAG_W-1:0] savedFlag, flagReg, nextFlag;
  logic [PC_W-1:0]   savedPc;
  logic [LVL_W-1:0]  heldLevel;
  logic              keepU, useUsp, keepUNow;

  assign inClass  = irqClass_e'(irqClass);
  assign keepUNow = (inClass == CLS_SOFT) && (swVector >= VEC_W'(SW_KEEP_BASE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ispReg    <= '0;
      uspReg    <= '0;
      savedFlag <= '0;
      savedPc   <= '0;
      heldLevel <= '0;
      heldClass <= CLS_RESET;
      keepU     <= 1'b0;
      useUsp    <= 1'b0;
    end else if (strobe.load) begin
      ispReg    <= ispIn;
      uspReg    <= uspIn;
      savedFlag <= flagIn;
      savedPc   <= pcIn;
      heldLevel <= acceptLevel;
      heldClass <= inClass;
      keepU     <= keepUNow;
      useUsp    <= keepUNow & flagIn[BIT_USR];
    end else if (strobe.push) begin
      if (useUsp) uspReg <= uspReg - STEP;
      else        ispReg <= ispReg - STEP;
    end
  end

  always_comb begin
    nextFlag = savedFlag;
    nextFlag[BIT_IE]  = 1'b0;
    nextFlag[BIT_DBG] = 1'b0;
    if (!keepU) nextFlag[BIT_USR] = 1'b0;
    case (heldClass)
      CLS_RESET:          nextFlag[IPL_LSB +: LVL_W] = '0;
      CLS_NMI, CLS_WDOG:  nextFlag[IPL_LSB +: LVL_W] = '1;
      CLS_MASKABLE:       nextFlag[IPL_LSB +: LVL_W] = heldLevel;
      default:            ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              flagReg <= '0;
    else if (strobe.commit) flagReg <= nextFlag;
  end

  assign activeSp = useUsp ? uspReg : ispReg;
  assign memWe    = strobe.push;
  assign memAddr  = activeSp - STEP;

  always_comb begin
    case (strobe.word)
      WORD_FLAG: memData = savedFlag;
      WORD_PCHI: memData = SP_W'(savedPc[PC_W-1:SP_W]);
      WORD_PCLO: memData = savedPc[SP_W-1:0];
      default:   memData = '0;
    endcase
  end

  assign ispOut  = ispReg;
  assign uspOut  = uspReg;
  assign flagOut = flagReg;

  AST_ISP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !useUsp) |=> (ispOut == $past(ispOut) - STEP)); // R2
  AST_USP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !useUsp) |=> $stable(uspOut)); // R6
  AST_ISP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && useUsp) |=> $stable(ispOut)); // R6
  AST_FLAG_ONLY_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(flagOut)); // R7
  AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (!flagOut[BIT_IE] && !flagOut[BIT_DBG])); // R4
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irqseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        acceptStrobe,
  input  logic [2:0]  irqClass,
  input  logic [5:0]  swVector,
  input  logic [2:0]  acceptLevel,
  input  logic [15:0] flagIn,
  input  logic [19:0] pcIn,
  input  logic [15:0] ispIn,
  input  logic [15:0] uspIn,
  input  logic        nmiPin,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [15:0] memData,
  output logic [15:0] ispOut,
  output logic [15:0] uspOut,
  output logic [15:0] flagOut,
  output logic        busy,
  output logic        done,
  output logic        nmiPending
);
  seqStrobe_t strobe;
  logic       nmiAck;

  irqseq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .acceptStrobe (acceptStrobe),
    .strobe       (strobe),
    .busy         (busy),
    .done         (done)
  );

  irqseq_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .irqClass    (irqClass),
    .swVector    (swVector),
    .acceptLevel (acceptLevel),
    .flagIn      (flagIn),
    .pcIn        (pcIn),
    .ispIn       (ispIn),
    .uspIn       (uspIn),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memData     (memData),
    .ispOut      (ispOut),
    .uspOut      (uspOut),
    .flagOut     (flagOut)
  );

  assign nmiAck = strobe.load && (irqClass == CLS_NMI);

  irqseq_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk     (clk),
    .rstN    (rstN),
    .nmiPin  (nmiPin),
    .ack     (nmiAck),
    .pending (nmiPending)
  );
endmodule

// File: tb/irq_accept_seq_tb.sv
module irq_accept_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        acceptStrobe;
  logic [2:0]  irqClass;
  logic [5:0]  swVector;
  logic [2:0]  acceptLevel;
  logic [15:0] flagIn;
  logic [19:0] pcIn;
  logic [15:0] ispIn, uspIn;
  logic        nmiPin;
  logic        memWe, busy, done, nmiPending;
  logic [15:0] memAddr, memData, ispOut, uspOut, flagOut;

  int nChecks = 0;
  int nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_seq u_dut (
    .clk(clk), .rstN(rstN), .acceptStrobe(acceptStrobe), .irqClass(irqClass),
    .swVector(swVector), .acceptLevel(acceptLevel), .flagIn(flagIn), .pcIn(pcIn),
    .ispIn(ispIn), .uspIn(uspIn), .nmiPin(nmiPin), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .ispOut(ispOut), .uspOut(uspOut), .flagOut(flagOut),
    .busy(busy), .done(done), .nmiPending(nmiPending)
  );

  typedef struct packed {
    logic [2:0]  cls;
    logic [5:0]  vec;
    logic [2:0]  lvl;
    logic [15:0] flag;
    logic [19:0] pc;
    logic [15:0] isp;
    logic [15:0] usp;
    logic [2:0]  expIpl;
    logic        expUsp;
    logic        keepU;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd7, 6'd0,  3'd5, 16'h20C2, 20'hABCDE, 16'h0400, 16'h0800, 3'd5, 1'b0, 1'b0},
    '{3'd1, 6'd0,  3'd3, 16'h30C2, 20'h12345, 16'h1000, 16'h2000, 3'd7, 1'b0, 1'b0},
    '{3'd6, 6'd40, 3'd1, 16'h4080, 20'h00FFE, 16'h0500, 16'h0A00, 3'd4, 1'b1, 1'b1},
    '{3'd6, 6'd63, 3'd1, 16'h4000, 20'hF0001, 16'h0600, 16'h0B00, 3'd4, 1'b0, 1'b1},
    '{3'd6, 6'd31, 3'd2, 16'h6082, 20'h54321, 16'h0700, 16'h0C00, 3'd6, 1'b0, 1'b0},
    '{3'd0, 6'd0,  3'd6, 16'h7042, 20'h00000, 16'h0800, 16'h0D00, 3'd0, 1'b0, 1'b0},
    '{3'd2, 6'd0,  3'd0, 16'h1000, 20'h80000, 16'h0900, 16'h0E00, 3'd7, 1'b0, 1'b0},
    '{3'd4, 6'd32, 3'd1, 16'h3042, 20'h11111, 16'h0A00, 16'h0F00, 3'd3, 1'b0, 1'b0},
    '{3'd3, 6'd0,  3'd7, 16'h2080, 20'h22222, 16'h0B00, 16'h1100, 3'd2, 1'b0, 1'b0},
    '{3'd5, 6'd0,  3'd4, 16'h5002, 20'h33333, 16'h0C00, 16'h1200, 3'd5, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] expFlag(input vec_t v);
    logic [15:0] f;
    f = v.flag & ~16'h7042;
    if (!v.keepU) f[7] = 1'b0;
    f[14:12] = v.expIpl;
    return f;
  endfunction

  task automatic drive(input logic [2:0] c, input logic [5:0] sv, input logic [2:0] l,
                       input logic [15:0] f, input logic [19:0] p,
                       input logic [15:0] i, input logic [15:0] u);
    irqClass = c; swVector = sv; acceptLevel = l;
    flagIn = f; pcIn = p; ispIn = i; uspIn = u;
  endtask

  task automatic runVec(input vec_t v);
    logic [15:0] sp, other;
    sp    = v.expUsp ? v.usp : v.isp;
    other = v.expUsp ? v.isp : v.usp;
    drive(v.cls, v.vec, v.lvl, v.flag, v.pc, v.isp, v.usp);
    acceptStrobe = 1'b1;
    step();
    acceptStrobe = 1'b0;
    check("R1 busy", 32'(busy), 32'd1);
    check("R1 we flag", 32'(memWe), 32'd1);
    check("R3 addr flag", 32'(memAddr), 32'(sp - 16'd2));
    check("R4 saved flag", 32'(memData), 32'(v.flag));
    step();
    check("R2 addr pchi", 32'(memAddr), 32'(sp - 16'd4));
    check("R2 data pchi", 32'(memData), 32'(v.pc[19:16]));
    step();
    check("R2 addr pclo", {memWe, 15'd0, memAddr}, {1'b1, 15'd0, sp - 16'd6});
    check("R2 data pclo", 32'(memData), 32'(v.pc[15:0]));
    step();
    check("R7 done", {done, memWe}, {1'b1, 1'b0});
    check("R5 R4 R3 flag", 32'(flagOut), 32'(expFlag(v)));
    check("R2 final sp", 32'(v.expUsp ? uspOut : ispOut), 32'(sp - 16'd6));
    check("R6 unused sp", 32'(v.expUsp ? ispOut : uspOut), 32'(other));
    step();
    check("R7 done pulse", {done, busy}, 2'b00);
  endtask

  initial begin
    rstN = 1'b0; acceptStrobe = 1'b0; nmiPin = 1'b1;
    drive(3'd0, 6'd0, 3'd0, 16'h0, 20'h0, 16'h0, 16'h0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset outputs", {busy, done, memWe, nmiPending}, 4'b0000);
    check("R7 reset flag", 32'(flagOut), 32'd0);

    for (int k = 0; k < NV; k++) runVec(VECS[k]);

    // R8: accept while busy is ignored
    drive(3'd7, 6'd0, 3'd2, 16'h00C2, 20'h12345, 16'h0400, 16'h0800);
    acceptStrobe = 1'b1;
    step();
    acceptStrobe = 1'b0;
    step();
    drive(3'd1, 6'd50, 3'd6, 16'hFFFF, 20'hFFFFF, 16'h9000, 16'h9000);
    acceptStrobe = 1'b1;
    check("R8 addr pchi", 32'(memAddr), 32'h03FC);
    step();
    check("R8 addr pclo", 32'(memAddr), 32'h03FA);
    check("R8 data pclo", 32'(memData), 32'h2345);
    step();
    acceptStrobe = 1'b0;
    check("R8 done", 32'(done), 32'd1);
    check("R8 sp", {ispOut, uspOut}, {16'h03FA, 16'h0800});
    check("R8 flag", 32'(flagOut), 32'h2000);
    step();
    check("R8 idle", {busy, memWe, done}, 3'b000);
    step();
    check("R8 flag held", 32'(flagOut), 32'h2000);

    // R9: falling edge detection timing
    nmiPin = 1'b0;
    step();
    step();
    check("R9 not yet pending", 32'(nmiPending), 32'd0);
    step();
    check("R9 pending", 32'(nmiPending), 32'd1);
    repeat (4) step();
    check("R9 pending held", 32'(nmiPending), 32'd1);
    nmiPin = 1'b1;
    repeat (5) step();
    check("R9 rising keeps", 32'(nmiPending), 32'd1);
    drive(3'd7, 6'd0, 3'd1, 16'h0000, 20'h0, 16'h0400, 16'h0800);
    acceptStrobe = 1'b1;
    step();
    acceptStrobe = 1'b0;
    check("R9 non-nmi no clear", 32'(nmiPending), 32'd1);
    repeat (4) step();
    drive(3'd1, 6'd0, 3'd0, 16'h0000, 20'h0, 16'h0400, 16'h0800);
    acceptStrobe = 1'b1;
    step();
    acceptStrobe = 1'b0;
    check("R9 ack clears", 32'(nmiPending), 32'd0);
    repeat (6) step();
    check("R9 no edge no pending", 32'(nmiPending), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule